// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block is the exception-entry half of a 32-bit processor's system control coprocessor. The pipeline hands it at most one exception request per cycle. Each request carries a kind code, the PC of the faulting instruction, a flag saying whether that instruction sat in a branch delay slot, and a cause code for ordinary exceptions. The block then updates its machine-state registers (Status, Cause, EPC, ErrorEPC, DEPC and the debug-mode flag). In the same cycle it presents the PC the pipeline must fetch from next, together with a one-cycle redirect strobe.

Requests fall into three groups. The reset-like kinds are hard reset, soft reset and non-maskable interrupt. These all restart at the boot address and record the return point in ErrorEPC. Debug entry records its return point in DEPC and jumps to the debug vector. Ordinary exceptions record their return point in EPC and flag a delay slot in Cause. They jump to a vector whose base is chosen by the boot-exception-vector bit of Status. When the faulting instruction sits in a delay slot, the saved PC is wound back one instruction so that the branch is re-executed.

The pipeline also asks the block whether a coprocessor-0 access must trap. A single write port lets software load Status. The request input is a valid/ready stream whose ready is held high, so the pipeline never has to stall on it.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After `rst_n` is released, the outputs read as follows. Status is 0x00400004, with BEV at bit 22 and ERL at bit 2. Cause, EPC, ErrorEPC and DEPC are 0. `debug_mode`, `redirect_valid` and `type_error` are 0. `random` is TLB_ENTRIES-1, which is 15 by default.
- R2: A hard-reset request (`req_kind`=0) has four effects. It redirects to 0xBFC00000 and sets Status to exactly 0x00400004, so CU0 at bit 28 ends up clear. It clears `debug_mode` and sets `random` to TLB_ENTRIES-1.
- R3: A soft-reset request (`req_kind`=1) sets Status to exactly 0x00500004, which is SR at bit 20 plus BEV and ERL. It redirects to 0xBFC00000.
- R4: An NMI request (`req_kind`=2) sets Status to exactly 0x00480004, which is the NMI flag at bit 19 plus BEV and ERL. It redirects to 0xBFC00000.
- R5: For request kinds 0, 1 and 2, ErrorEPC receives `req_pc`-4 when `req_in_delay` is 1 and `req_pc` otherwise.
- R6: A debug request (`req_kind`=3) has three effects. It sets `debug_mode` and redirects to 0xBFC00480. DEPC receives `req_pc`-4 when `req_in_delay` is 1 and `req_pc` otherwise. Status is left unchanged.
- R7: Ordinary requests are refill (`req_kind`=4), general (`req_kind`=5) and machine check (`req_kind`=6). Each redirects to a base plus an offset. The base is 0xBFC00200 when Status bit 22 is 1 and 0x80000000 when it is 0. The offset is 0x000 for refill and 0x180 for the other two.
- R8: For an ordinary request, EPC receives `req_pc`-4 and Cause bit 31 is set when `req_in_delay` is 1. Otherwise EPC receives `req_pc` and Cause bit 31 is cleared.
- R9: An ordinary request sets Status bit 1 (EXL) and keeps the other Status bits. It writes the exception code into Cause bits 6:2, and leaves Cause bits 30:7 and 1:0 unchanged. The code is `req_code` for refill and general, and 24 for machine check.
- R10: `redirect_valid` is high for exactly one cycle, the cycle after an accepted request of kind 0 to 6. In that cycle `redirect_pc` and all register outputs already show the new values.
- R11: An accepted request of kind 7 raises `type_error` for one cycle. It produces no redirect and changes no register.
- R12: `cp0_trap` is 1 only under all of the following conditions: `cp0_access` and `user_mode` are 1, and Status bits 28 (CU0), 2 (ERL) and 1 (EXL) are all 0.
- R13: When `st_wr_en` is 1, Status takes `st_wr_data` on the next cycle. If a request is accepted in the same cycle, the write is dropped.
- R14: `req_ready` is always 1, so a request is accepted in every cycle that `req_valid` is 1, including back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Exception request present |
| req_ready | output | 1 | Request accepted; always 1 |
| req_kind | input | 3 | Request kind, 0..6 valid, 7 unknown |
| req_pc | input | 32 | PC of the faulting instruction |
| req_in_delay | input | 1 | Faulting instruction is in a branch delay slot |
| req_code | input | 5 | Exception code for refill and general requests |
| st_wr_en | input | 1 | Status write strobe |
| st_wr_data | input | 32 | Status write value |
| cp0_access | input | 1 | Current instruction accesses coprocessor 0 |
| user_mode | input | 1 | Core is in user mode |
| cp0_trap | output | 1 | Coprocessor-0 access must trap |
| redirect_valid | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | 32 | Fetch target for the redirect |
| type_error | output | 1 | One-cycle unknown-kind flag |
| status | output | 32 | Status register |
| cause | output | 32 | Cause register |
| epc | output | 32 | Ordinary-exception return PC |
| error_epc | output | 32 | Reset/NMI return PC |
| depc | output | 32 | Debug return PC |
| debug_mode | output | 1 | Debug mode flag |
| random | output | $clog2(TLB_ENTRIES) | Random register |

## Verification
The hardest state to reach from the ports is an ordinary exception with BEV clear. Both reset paths leave BEV set, so the only way to clear it is the Status write port. The stimulus therefore writes Status before raising refill and general requests, then writes BEV back to 1 before the machine-check request, so that both vector bases are exercised. Collisions are set up on purpose by raising a Status write in the same cycle as a request, once with a valid kind and once with the unknown kind, to show that the request wins and that the unknown kind leaves every register untouched.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  typedef enum logic [2:0] {
    KIND_HARD_RST = 3'd0,
    KIND_SOFT_RST = 3'd1,
    KIND_NMI      = 3'd2,
    KIND_DEBUG    = 3'd3,
    KIND_REFILL   = 3'd4,
    KIND_GENERAL  = 3'd5,
    KIND_MCHECK   = 3'd6,
    KIND_BAD      = 3'd7
  } exc_kind_e;

  typedef enum logic [2:0] {
    CLS_HARD  = 3'd0,
    CLS_SOFT  = 3'd1,
    CLS_NMI   = 3'd2,
    CLS_DEBUG = 3'd3,
    CLS_ORD   = 3'd4,
    CLS_NONE  = 3'd5
  } exc_class_e;

  localparam int ST_CU0  = 28;
  localparam int ST_BEV  = 22;
  localparam int ST_SR   = 20;
  localparam int ST_NMI  = 19;
  localparam int ST_ERL  = 2;
  localparam int ST_EXL  = 1;
  localparam int CA_BD   = 31;
  localparam int CA_CODE_LO = 2;
endpackage

// File: rtl/exc_decode.sv
`timescale 1ns/1ps
module exc_decode
  import exc_pkg::*;
#(
  parameter int ECODE_W = 5,
  parameter int OFF_W = 12,
  parameter logic [OFF_W-1:0] REFILL_OFF = 12'h000,
  parameter logic [OFF_W-1:0] GEN_OFF = 12'h180,
  parameter int MCHECK_CODE = 24
) (
  input  exc_kind_e           kind,
  input  logic [ECODE_W-1:0]  code_in,
  output exc_class_e          cls,
  output logic [ECODE_W-1:0]  code_out,
  output logic [OFF_W-1:0]    offset
);
  always_comb begin
    cls      = CLS_NONE;
    code_out = code_in;
    offset   = '0;
    unique case (kind)
      KIND_HARD_RST: cls = CLS_HARD;
      KIND_SOFT_RST: cls = CLS_SOFT;
      KIND_NMI:      cls = CLS_NMI;
      KIND_DEBUG:    cls = CLS_DEBUG;
      KIND_REFILL: begin
        cls    = CLS_ORD;
        offset = REFILL_OFF;
      end
      KIND_GENERAL: begin
        cls    = CLS_ORD;
        offset = GEN_OFF;
      end
      KIND_MCHECK: begin
        cls      = CLS_ORD;
        offset   = GEN_OFF;
        code_out = ECODE_W'(MCHECK_CODE);
      end
      default: cls = CLS_NONE;
    endcase
  end
endmodule

// File: rtl/exc_target.sv
`timescale 1ns/1ps
module exc_target
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter int OFF_W = 12,
  parameter int INSN_BYTES = 4,
  parameter logic [AW-1:0] RESET_VEC = 32'hBFC0_0000,
  parameter logic [AW-1:0] DEBUG_VEC = 32'hBFC0_0480,
  parameter logic [AW-1:0] BOOT_BASE = 32'hBFC0_0200,
  parameter logic [AW-1:0] NORM_BASE = 32'h8000_0000
) (
  input  exc_class_e         cls,
  input  logic [OFF_W-1:0]   offset,
  input  logic [AW-1:0]      pc,
  input  logic               in_delay,
  input  logic               bev,
  output logic [AW-1:0]      target,
  output logic [AW-1:0]      saved
);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

  logic [AW-1:0] ord_base;

  assign saved    = in_delay ? (pc - STEP) : pc;
  assign ord_base = bev ? BOOT_BASE : NORM_BASE;

  always_comb begin
    unique case (cls)
      CLS_HARD, CLS_SOFT, CLS_NMI: target = RESET_VEC;
      CLS_DEBUG:                   target = DEBUG_VEC;
      CLS_ORD:                     target = ord_base + AW'(offset);
      default:                     target = '0;
    endcase
  end
endmodule

// File: rtl/exc_state.sv
`timescale 1ns/1ps
module exc_state
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter int ECODE_W = 5,
  parameter int RAND_W = 4,
  parameter int TLB_ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  exc_class_e         cls,
  input  logic [ECODE_W-1:0] code,
  input  logic               in_delay,
  input  logic [AW-1:0]      target,
  input  logic [AW-1:0]      saved,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_data,
  output logic [AW-1:0]      status,
  output logic [AW-1:0]      cause,
  output logic [AW-1:0]      epc,
  output logic [AW-1:0]      error_epc,
  output logic [AW-1:0]      depc,
  output logic               debug_mode,
  output logic [RAND_W-1:0]  random,
  output logic               redirect_valid,
  output logic [AW-1:0]      redirect_pc,
  output logic               type_error
);
  localparam logic [AW-1:0] BIT_BEV = AW'(1) << ST_BEV;
  localparam logic [AW-1:0] BIT_ERL = AW'(1) << ST_ERL;
  localparam logic [AW-1:0] BIT_EXL = AW'(1) << ST_EXL;
  localparam logic [AW-1:0] ST_BOOT = BIT_BEV | BIT_ERL;
  localparam logic [AW-1:0] ST_SOFT = ST_BOOT | (AW'(1) << ST_SR);
  localparam logic [AW-1:0] ST_NMIV = ST_BOOT | (AW'(1) << ST_NMI);
  localparam logic [RAND_W-1:0] RAND_INIT = RAND_W'(TLB_ENTRIES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status         <= ST_BOOT;
      cause          <= '0;
      epc            <= '0;
      error_epc      <= '0;
      depc           <= '0;
      debug_mode     <= 1'b0;
      random         <= RAND_INIT;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      type_error     <= 1'b0;
    end else begin
      redirect_valid <= 1'b0;
      type_error     <= 1'b0;
      if (take) begin
        unique case (cls)
          CLS_HARD: begin
            status     <= ST_BOOT;
            error_epc  <= saved;
            debug_mode <= 1'b0;
            random     <= RAND_INIT;
          end
          CLS_SOFT: begin
            status    <= ST_SOFT;
            error_epc <= saved;
          end
          CLS_NMI: begin
            status    <= ST_NMIV;
            error_epc <= saved;
          end
          CLS_DEBUG: begin
            depc       <= saved;
            debug_mode <= 1'b1;
          end
          CLS_ORD: begin
            epc    <= saved;
            status <= status | BIT_EXL;
            cause[CA_BD] <= in_delay;
            cause[CA_CODE_LO +: ECODE_W] <= code;
          end
          default: ;
        endcase
        if (cls == CLS_NONE) begin
          type_error <= 1'b1;
        end else begin
          redirect_valid <= 1'b1;
          redirect_pc    <= target;
        end
      end else if (wr_en) begin
        status <= wr_data;
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int TLB_ENTRIES = 16,
  parameter int ECODE_W = 5,
  localparam int AW = 32,
  localparam int OFF_W = 12,
  localparam int RAND_W = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_kind,
  input  logic [AW-1:0]      req_pc,
  input  logic               req_in_delay,
  input  logic [ECODE_W-1:0] req_code,
  input  logic               st_wr_en,
  input  logic [AW-1:0]      st_wr_data,
  input  logic               cp0_access,
  input  logic               user_mode,
  output logic               cp0_trap,
  output logic               redirect_valid,
  output logic [AW-1:0]      redirect_pc,
  output logic               type_error,
  output logic [AW-1:0]      status,
  output logic [AW-1:0]      cause,
  output logic [AW-1:0]      epc,
  output logic [AW-1:0]      error_epc,
  output logic [AW-1:0]      depc,
  output logic               debug_mode,
  output logic [RAND_W-1:0]  random
);
  exc_class_e         cls;
  logic [ECODE_W-1:0] code;
  logic [OFF_W-1:0]   offset;
  logic [AW-1:0]      target;
  logic [AW-1:0]      saved;
  logic               take;

  assign req_ready = 1'b1;
  assign take      = req_valid && req_ready;

  exc_decode #(.ECODE_W(ECODE_W), .OFF_W(OFF_W)) u_decode (
    .kind     (exc_kind_e'(req_kind)),
    .code_in  (req_code),
    .cls      (cls),
    .code_out (code),
    .offset   (offset)
  );

  exc_target #(.AW(AW), .OFF_W(OFF_W)) u_target (
    .cls      (cls),
    .offset   (offset),
    .pc       (req_pc),
    .in_delay (req_in_delay),
    .bev      (status[ST_BEV]),
    .target   (target),
    .saved    (saved)
  );

  exc_state #(
    .AW(AW), .ECODE_W(ECODE_W), .RAND_W(RAND_W), .TLB_ENTRIES(TLB_ENTRIES)
  ) u_state (
    .clk            (clk),
    .rst_n          (rst_n),
    .take           (take),
    .cls            (cls),
    .code           (code),
    .in_delay       (req_in_delay),
    .target         (target),
    .saved          (saved),
    .wr_en          (st_wr_en),
    .wr_data        (st_wr_data),
    .status         (status),
    .cause          (cause),
    .epc            (epc),
    .error_epc      (error_epc),
    .depc           (depc),
    .debug_mode     (debug_mode),
    .random         (random),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .type_error     (type_error)
  );

  assign cp0_trap = cp0_access && user_mode && !status[ST_CU0] &&
                    !status[ST_ERL] && !status[ST_EXL];
endmodule

// File: rtl/exc_entry_checker.sv
`timescale 1ns/1ps
module exc_entry_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [2:0]  req_kind,
  input logic        redirect_valid,
  input logic [31:0] redirect_pc,
  input logic        type_error,
  input logic [31:0] status,
  input logic [31:0] cause,
  input logic [31:0] epc,
  input logic [31:0] error_epc,
  input logic [31:0] depc,
  input logic        debug_mode
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_redirect_after_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind != 3'd7) |=> (redirect_valid && !type_error));

  assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> (!redirect_valid && !type_error));

  assert_bad_kind_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind == 3'd7) |=> (type_error && !redirect_valid && $stable(status) &&
      $stable(cause) && $stable(epc) && $stable(error_epc) && $stable(depc) &&
      $stable(debug_mode)));

  assert_debug_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind == 3'd3) |=> (redirect_pc == 32'hBFC0_0480 && debug_mode && $stable(status)));

  assert_reset_class_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind <= 3'd2) |=> (redirect_pc == 32'hBFC0_0000 && status[2] && status[22] &&
      !status[28] && !status[1]));

  assert_ordinary_sets_exl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind >= 3'd4 && req_kind <= 3'd6) |=> (status[1] && $stable(error_epc)));

  assert_ready_high_R14: assert property (@(posedge clk) disable iff (!rst_n) req_ready);
endmodule

bind exc_entry_ctrl exc_entry_checker u_exc_entry_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_kind       (req_kind),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .type_error     (type_error),
  .status         (status),
  .cause          (cause),
  .epc            (epc),
  .error_epc      (error_epc),
  .depc           (depc),
  .debug_mode     (debug_mode)
);

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = 3'd0;
  logic [31:0] req_pc = 32'd0;
  logic        req_in_delay = 1'b0;
  logic [4:0]  req_code = 5'd0;
  logic        st_wr_en = 1'b0;
  logic [31:0] st_wr_data = 32'd0;
  logic        cp0_access = 1'b0;
  logic        user_mode = 1'b0;
  logic        cp0_trap, redirect_valid, type_error, debug_mode;
  logic [31:0] redirect_pc, status, cause, epc, error_epc, depc;
  logic [3:0]  random;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  exc_entry_ctrl u_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_pc(req_pc), .req_in_delay(req_in_delay),
    .req_code(req_code), .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
    .cp0_access(cp0_access), .user_mode(user_mode), .cp0_trap(cp0_trap),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .type_error(type_error), .status(status), .cause(cause), .epc(epc),
    .error_epc(error_epc), .depc(depc), .debug_mode(debug_mode), .random(random)
  );

  // behavioural reference model
  logic [31:0] m_status, m_cause, m_epc, m_eepc, m_depc, m_rpc;
  logic        m_rv, m_err, m_dbg;
  logic [31:0] m_saved;
  assign m_saved = req_in_delay ? req_pc - 32'd4 : req_pc;

  function automatic logic [31:0] ord_vec(input logic bev, input logic [2:0] k);
    logic [31:0] base = bev ? 32'hBFC0_0200 : 32'h8000_0000;
    return base + ((k == 3'd4) ? 32'h0 : 32'h180);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_status <= 32'h0040_0004; m_cause <= 0; m_epc <= 0; m_eepc <= 0;
      m_depc <= 0; m_rpc <= 0; m_rv <= 0; m_err <= 0; m_dbg <= 0;
    end else begin
      m_rv <= 1'b0;
      m_err <= 1'b0;
      if (req_valid) begin
        if (req_kind == 3'd7) m_err <= 1'b1;
        else begin m_rv <= 1'b1; end
        case (req_kind)
          3'd0: begin m_status <= 32'h0040_0004; m_eepc <= m_saved; m_dbg <= 0; m_rpc <= 32'hBFC0_0000; end
          3'd1: begin m_status <= 32'h0050_0004; m_eepc <= m_saved; m_rpc <= 32'hBFC0_0000; end
          3'd2: begin m_status <= 32'h0048_0004; m_eepc <= m_saved; m_rpc <= 32'hBFC0_0000; end
          3'd3: begin m_depc <= m_saved; m_dbg <= 1; m_rpc <= 32'hBFC0_0480; end
          3'd4, 3'd5, 3'd6: begin
            m_epc <= m_saved;
            m_status <= m_status | 32'h2;
            m_rpc <= ord_vec(m_status[22], req_kind);
            m_cause <= {req_in_delay, m_cause[30:7],
                        (req_kind == 3'd6) ? 5'd24 : req_code, m_cause[1:0]};
          end
          default: ;
        endcase
      end else if (st_wr_en) m_status <= st_wr_data;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R10 model redirect_valid", {31'b0, redirect_valid}, {31'b0, m_rv});
      chk("R11 model type_error", {31'b0, type_error}, {31'b0, m_err});
      if (m_rv) chk("R7 model redirect_pc", redirect_pc, m_rpc);
      chk("R9 model status", status, m_status);
      chk("R8 model cause", cause, m_cause);
      chk("R8 model epc", epc, m_epc);
      chk("R5 model error_epc", error_epc, m_eepc);
      chk("R6 model depc", depc, m_depc);
      chk("R6 model debug_mode", {31'b0, debug_mode}, {31'b0, m_dbg});
    end
  end

  task automatic issue(input logic [2:0] k, input logic [31:0] pc, input logic ds,
                       input logic [4:0] code, input logic we, input logic [31:0] wd);
    req_valid = 1'b1; req_kind = k; req_pc = pc; req_in_delay = ds; req_code = code;
    st_wr_en = we; st_wr_data = wd;
    @(negedge clk);
    req_valid = 1'b0; st_wr_en = 1'b0;
  endtask

  task automatic wr_status(input logic [31:0] wd);
    st_wr_en = 1'b1; st_wr_data = wd;
    @(negedge clk);
    st_wr_en = 1'b0;
  endtask

  task automatic summary();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        failures++;
        $display("FAIL watchdog expired");
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 32'h0040_0004);
    chk("R1 cause", cause, 0);
    chk("R1 epc", epc, 0);
    chk("R1 error_epc", error_epc, 0);
    chk("R1 depc", depc, 0);
    chk("R1 random", {28'b0, random}, 32'd15);
    chk("R1 redirect", {30'b0, redirect_valid, debug_mode}, 0);
    chk("R14 ready", {31'b0, req_ready}, 1);

    // R13 status write, clear BEV
    wr_status(32'h0);
    chk("R13 status written", status, 32'h0);

    // general, BEV=0, no delay slot
    issue(3'd5, 32'h0000_1000, 1'b0, 5'd5, 1'b0, 0);
    chk("R10 strobe", {31'b0, redirect_valid}, 1);
    chk("R7 general BEV0 vector", redirect_pc, 32'h8000_0180);
    chk("R8 epc no delay", epc, 32'h0000_1000);
    chk("R9 cause code", cause, 32'h0000_0014);
    chk("R9 exl set", status, 32'h0000_0002);
    // refill back-to-back, delay slot
    issue(3'd4, 32'h0000_2004, 1'b1, 5'd2, 1'b0, 0);
    chk("R14 back-to-back strobe", {31'b0, redirect_valid}, 1);
    chk("R7 refill BEV0 vector", redirect_pc, 32'h8000_0000);
    chk("R8 epc delay", epc, 32'h0000_2000);
    chk("R8 cause bd", cause, 32'h8000_0008);
    @(negedge clk);
    chk("R10 strobe single", {31'b0, redirect_valid}, 0);

    // BEV=1 then machine check
    wr_status(32'h0040_0000);
    issue(3'd6, 32'h0000_3000, 1'b0, 5'd3, 1'b0, 0);
    chk("R7 mcheck BEV1 vector", redirect_pc, 32'hBFC0_0380);
    chk("R9 mcheck code 24", cause, 32'h0000_0060);
    chk("R9 status keeps bits", status, 32'h0040_0002);

    // debug entry, delay slot
    issue(3'd3, 32'h0000_4008, 1'b1, 5'd0, 1'b0, 0);
    chk("R6 debug vector", redirect_pc, 32'hBFC0_0480);
    chk("R6 depc", depc, 32'h0000_4004);
    chk("R6 debug flag", {31'b0, debug_mode}, 1);
    chk("R6 status unchanged", status, 32'h0040_0002);

    // NMI, delay slot
    issue(3'd2, 32'h0000_5010, 1'b1, 5'd0, 1'b0, 0);
    chk("R4 nmi status", status, 32'h0048_0004);
    chk("R4 nmi vector", redirect_pc, 32'hBFC0_0000);
    chk("R5 nmi error_epc", error_epc, 32'h0000_500C);

    // soft reset, no delay slot
    issue(3'd1, 32'h0000_6000, 1'b0, 5'd0, 1'b0, 0);
    chk("R3 soft status", status, 32'h0050_0004);
    chk("R5 soft error_epc", error_epc, 32'h0000_6000);

    // unknown kind with a colliding status write
    issue(3'd7, 32'h0000_9990, 1'b1, 5'd9, 1'b1, 32'h1234_5678);
    chk("R11 type_error", {31'b0, type_error}, 1);
    chk("R11 no redirect", {31'b0, redirect_valid}, 0);
    chk("R11 status kept", status, 32'h0050_0004);
    chk("R11 error_epc kept", error_epc, 32'h0000_6000);
    chk("R11 epc kept", epc, 32'h0000_3000);

    // R12 coprocessor-0 trap
    wr_status(32'h0);
    cp0_access = 1'b1; user_mode = 1'b1;
    #1 chk("R12 trap user", {31'b0, cp0_trap}, 1);
    user_mode = 1'b0;
    #1 chk("R12 no trap kernel", {31'b0, cp0_trap}, 0);
    user_mode = 1'b1;
    wr_status(32'h1000_0000);
    chk("R12 no trap cu0", {31'b0, cp0_trap}, 0);
    wr_status(32'h0000_0002);
    chk("R12 no trap exl", {31'b0, cp0_trap}, 0);
    wr_status(32'h0000_0004);
    chk("R12 no trap erl", {31'b0, cp0_trap}, 0);
    cp0_access = 1'b0;

    // R13 request beats simultaneous write
    wr_status(32'h0);
    issue(3'd5, 32'h0000_7100, 1'b0, 5'd8, 1'b1, 32'hFFFF_FFFF);
    chk("R13 request wins", status, 32'h0000_0002);

    // R2 hard reset request from debug mode, delay slot
    issue(3'd3, 32'h0000_7200, 1'b0, 5'd0, 1'b0, 0);
    issue(3'd0, 32'h0000_7004, 1'b1, 5'd0, 1'b0, 0);
    chk("R2 hard status", status, 32'h0040_0004);
    chk("R2 hard vector", redirect_pc, 32'hBFC0_0000);
    chk("R2 debug cleared", {31'b0, debug_mode}, 0);
    chk("R2 random", {28'b0, random}, 32'd15);
    chk("R5 hard error_epc", error_epc, 32'h0000_7000);

    @(negedge clk);
    summary();
  end
endmodule